// File: doc/BRIEF.md
# Serial Frequency-Synthesizer Loader

This block programs an external serial frequency synthesizer after reset. It uses three output lines: a framing strobe, a serial clock and a serial data line. It sends three words, each framed by its own strobe, and always in the same order. The first is an 8-bit setup word. The second is a 15-bit reference-divider word that sets a 100 kHz comparison rate from a 4 MHz reference. The third is a 16-bit feedback-divider word, which picks the tuned channel of an FM broadcast band in 100 kHz steps.

The feedback divider is a fixed base of 876 plus an 8-bit unsigned channel-select value. The channel value is taken when the load starts.

The bit rate is set by a parameter: the number of system clocks per half serial-bit period. At the end of the load the block raises a one-cycle done pulse and then goes quiet. After that, a reload pulse takes a fresh channel value and resends only the feedback-divider word. A reload pulse that arrives while a transfer is running has no effect.

Top module: `synth_loader`

## Requirements
- R1: While reset is held, and right after it, the strobe `syn_en` is 1 and `syn_clk`, `busy` and `done` are 0.
- R2: After each reset release, exactly three words go out, one frame each: setup word, then reference word, then divider word.
- R3: The setup word is 8 bits wide with the value 0x64. Its fields are:
  - bit 7 = 0: output polarity unchanged.
  - bit 6 = 1: differential phase detector.
  - bit 5 = 1: lock detect on.
  - bits 4:2 = 001: reference output at divide-by-1.
  - bits 1:0 = 0: the two divider test outputs off.
- R4: The reference word is 15 bits wide with the value 40.
- R5: The divider word is 16 bits wide and equals 876 plus `chan_sel` (8-bit unsigned). The carry out of the low byte reaches the high byte; for example, 0x94 gives 1024 and 255 gives 1131.
- R6: Words go out most-significant bit first. The receiver takes each bit on the rising edge of `syn_clk`. `syn_dat` does not change while `syn_clk` is high.
- R7: `syn_clk` idles low and is high only while `syn_en` is 0. `syn_en` falls before the first bit of a frame and rises with `syn_clk` low after the last bit; that rising edge latches the word.
- R8: Frame timing, with HALF_DIV system clocks per half bit:
  - the first rising edge of `syn_clk` comes 2*HALF_DIV clocks after `syn_en` falls;
  - later rising edges within a frame are 2*HALF_DIV clocks apart;
  - between two frames of one load, `syn_en` stays high for at least 2*HALF_DIV clocks.
- R9: `busy` is 1 whenever `syn_en` is 0. It falls on the last strobe rise of a load. `done` then pulses high for exactly one cycle, once per load.
- R10: A one-cycle `reload` pulse while idle takes `chan_sel` at that cycle and sends exactly one frame, the divider word. Later changes to `chan_sel` do not change that frame.
- R11: A `reload` pulse while `busy` is 1 is ignored: no extra frame and no extra `done` pulse.
- R12: After a load completes and with no reload, the lines stay quiet: `syn_en` is 1, `syn_clk` is 0 and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; its release starts the full load |
| chan_sel | input | 8 | Channel-select value added to the divider base |
| reload | input | 1 | Pulse that resends only the divider word |
| syn_en | output | 1 | Frame strobe: low while a word shifts, rise latches the word |
| syn_clk | output | 1 | Serial bit clock, idles low |
| syn_dat | output | 1 | Serial data, MSB first |
| busy | output | 1 | High while a load is in progress |
| done | output | 1 | One-cycle pulse after the last word is latched |

## Verification
The bench builds the block with HALF_DIV = 3. This gives a 6-clock bit period that is not a power of two. Every half-bit phase is then long enough to measure, so the bench can check the first-edge delay, the bit spacing and the inter-frame strobe gap to the exact cycle. All other parameters keep their defaults. This means the 876 base, the 15- and 16-bit word lengths and the low-byte carry cases (0x93 against 0x94, and 255) are checked as they would be used.

// File: rtl/synth_loader_pkg.sv
// Shared types for the serial synthesizer loader.
// Assumes: three words per full load, sent in enum order.
package synth_loader_pkg;

    // Phases of the frame sequencer
    typedef enum logic [2:0] {
        ST_PRE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_LATCH,
        ST_GAP,
        ST_IDLE
    } seq_state_t;

    // Word identifiers; the numeric order is the transmit order
    typedef enum logic [1:0] {
        W_CFG = 2'd0,
        W_REF = 2'd1,
        W_DIV = 2'd2
    } word_sel_t;

endpackage

// File: rtl/synth_loader_tick.sv
// Half-bit phase timer: emits a one-cycle tick every HALF_DIV clocks while
// run is high, and restarts from zero whenever run is low.
// Assumes: HALF_DIV >= 1.
module synth_loader_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // End of a half-bit phase
    assign tick = run && (cnt == LAST);

    // Phase counter, held at zero while not running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/synth_loader_divcalc.sv
// Channel-to-divider arithmetic: base offset plus unsigned channel value,
// at full output width so the low-byte carry reaches the upper bits.
// Assumes: OUT_W is wide enough for BASE + 2**CH_W - 1.
module synth_loader_divcalc #(
    parameter int CH_W  = 8,
    parameter int OUT_W = 16,
    parameter int BASE  = 876
) (
    input  logic [CH_W-1:0]  chan,
    output logic [OUT_W-1:0] div_val
);
    // Widen both operands before adding
    always_comb begin
        div_val = OUT_W'(BASE) + OUT_W'(chan);
    end
endmodule

// File: rtl/synth_loader_shift.sv
// Serial word shifter: takes a word of ld_len bits, left-aligns it so the
// MSB is first, and shifts one bit per shift pulse.
// Assumes: W >= 2 and 1 <= ld_len <= W.
module synth_loader_shift #(
    parameter int W     = 16,
    parameter int LEN_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [W-1:0]     ld_val,
    input  logic [LEN_W-1:0] ld_len,
    input  logic             shift,
    output logic             bit_cur,
    output logic             bit_next,
    output logic             last_bit
);
    logic [W-1:0]     sr;
    logic [LEN_W-1:0] rem;

    assign bit_cur  = sr[W-1];
    assign bit_next = sr[W-2];
    assign last_bit = (rem == LEN_W'(1));

    // Load left-aligned word or advance by one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            rem <= '0;
        end else if (ld) begin
            sr  <= ld_val << (LEN_W'(W) - ld_len);
            rem <= ld_len;
        end else if (shift) begin
            sr  <= {sr[W-2:0], 1'b0};
            rem <= rem - 1'b1;
        end
    end
endmodule

// File: rtl/synth_loader.sv
// Serial synthesizer loader top.
// - After reset it frames three words (setup, reference, divider) on an
//   enable/clock/data serial link, MSB first.
// - Data changes only while the clock is low.
// - Each strobe rise latches a word.
// - A reload pulse in idle resends only the divider word.
// Assumes: HALF_DIV >= 1; chan_sel is already synchronous and debounced.
module synth_loader
    import synth_loader_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int CH_W     = 8,
    parameter int CFG_BITS = 8,
    parameter int CFG_VAL  = 'h64,
    parameter int REF_BITS = 15,
    parameter int REF_VAL  = 40,
    parameter int DIV_BITS = 16,
    parameter int DIV_BASE = 876
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            reload,
    output logic            syn_en,
    output logic            syn_clk,
    output logic            syn_dat,
    output logic            busy,
    output logic            done
);
    localparam int MAX_A = (CFG_BITS > REF_BITS) ? CFG_BITS : REF_BITS;
    localparam int MAXW  = (DIV_BITS > MAX_A) ? DIV_BITS : MAX_A;
    localparam int LEN_W = $clog2(MAXW + 1);

    seq_state_t         state;
    word_sel_t          word_idx;
    word_sel_t          ld_sel;
    logic               gap_cnt;
    logic               tick;
    logic               run;
    logic               ld;
    logic               sample;
    logic               shift;
    logic [MAXW-1:0]    ld_val;
    logic [LEN_W-1:0]   ld_len;
    logic [DIV_BITS-1:0] div_now;
    logic [DIV_BITS-1:0] div_q;
    logic               bit_cur;
    logic               bit_next;
    logic               last_bit;

    assign run = (state != ST_IDLE);

    synth_loader_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    synth_loader_divcalc #(.CH_W(CH_W), .OUT_W(DIV_BITS), .BASE(DIV_BASE)) u_div (
        .chan    (chan_sel),
        .div_val (div_now)
    );

    synth_loader_shift #(.W(MAXW), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld),
        .ld_val   (ld_val),
        .ld_len   (ld_len),
        .shift    (shift),
        .bit_cur  (bit_cur),
        .bit_next (bit_next),
        .last_bit (last_bit)
    );

    // Decide when a new word is loaded, and which word
    always_comb begin
        ld     = 1'b0;
        sample = 1'b0;
        ld_sel = word_idx;
        if (state == ST_PRE && tick) begin
            ld     = 1'b1;
            sample = 1'b1;
            ld_sel = W_CFG;
        end else if (state == ST_GAP && tick && gap_cnt) begin
            ld     = 1'b1;
            ld_sel = word_sel_t'(word_idx + 2'd1);
        end else if (state == ST_IDLE && reload) begin
            ld     = 1'b1;
            sample = 1'b1;
            ld_sel = W_DIV;
        end
        shift = (state == ST_HIGH) && tick && !last_bit;
    end

    // Select the value and length of the word being loaded
    always_comb begin
        case (ld_sel)
            W_CFG: begin
                ld_val = MAXW'(CFG_VAL);
                ld_len = LEN_W'(CFG_BITS);
            end
            W_REF: begin
                ld_val = MAXW'(REF_VAL);
                ld_len = LEN_W'(REF_BITS);
            end
            default: begin
                ld_val = sample ? MAXW'(div_now) : MAXW'(div_q);
                ld_len = LEN_W'(DIV_BITS);
            end
        endcase
    end

    // Hold the divider value taken at the start of a load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (sample) begin
            div_q <= div_now;
        end
    end

    // Frame sequencer driving the serial lines, busy and done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_PRE;
            word_idx <= W_CFG;
            gap_cnt  <= 1'b0;
            syn_en   <= 1'b1;
            syn_clk  <= 1'b0;
            syn_dat  <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_PRE: begin
                    if (tick) begin
                        syn_en   <= 1'b0;
                        busy     <= 1'b1;
                        word_idx <= W_CFG;
                        state    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        syn_dat <= bit_cur;
                        state   <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        syn_clk <= 1'b1;
                        state   <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        syn_clk <= 1'b0;
                        if (last_bit) begin
                            state <= ST_LATCH;
                        end else begin
                            syn_dat <= bit_next;
                            state   <= ST_LOW;
                        end
                    end
                end
                ST_LATCH: begin
                    if (tick) begin
                        syn_en <= 1'b1;
                        if (word_idx == W_DIV) begin
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            gap_cnt <= 1'b0;
                            state   <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_cnt) begin
                            syn_en   <= 1'b0;
                            word_idx <= ld_sel;
                            state    <= ST_SETUP;
                        end else begin
                            gap_cnt <= 1'b1;
                        end
                    end
                end
                ST_IDLE: begin
                    if (reload) begin
                        syn_en   <= 1'b0;
                        busy     <= 1'b1;
                        word_idx <= W_DIV;
                        state    <= ST_SETUP;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/synth_loader_chk.sv
// Protocol checker for the loader's serial lines and status outputs.
// Assumes: it is attached through the bind below.
module synth_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic syn_en,
    input logic syn_clk,
    input logic syn_dat,
    input logic busy,
    input logic done
);
    // R7: bit clock only inside a frame
    p_clk_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        syn_clk |-> !syn_en);

    // R7: strobe rises only with the clock low
    p_latch_clk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_en) |-> !syn_clk);

    // R6: data holds while the clock is high
    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_clk && $past(syn_clk)) |-> $stable(syn_dat));

    // R9: done lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done follows the end of busy
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9: a frame is always inside busy
    p_frame_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !syn_en |-> busy);

    // R12: lines are quiet when not busy
    p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (syn_en && !syn_clk));
endmodule

bind synth_loader synth_loader_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .syn_en  (syn_en),
    .syn_clk (syn_clk),
    .syn_dat (syn_dat),
    .busy    (busy),
    .done    (done)
);

// File: tb/synth_loader_tb.sv
// Bench for synth_loader: a port-level frame decoder, a channel vector
// table, then directed tests for reset, reload while busy, and quiet idle.
module synth_loader_tb;
    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] chan_sel;
    logic       reload;
    logic       syn_en, syn_clk, syn_dat, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    synth_loader #(.HALF_DIV(H)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_sel (chan_sel),
        .reload   (reload),
        .syn_en   (syn_en),
        .syn_clk  (syn_clk),
        .syn_dat  (syn_dat),
        .busy     (busy),
        .done     (done)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Frame decoder state, sampled at the falling clock edge
    int          frames = 0;
    int          done_cnt = 0;
    logic [31:0] words [32];
    int          lens  [32];
    logic [31:0] sh;
    int          nbits;
    int          since_fall, since_rise, en_high;
    logic        p_en = 1'b1, p_clk = 1'b0, p_dat = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            since_fall++;
            since_rise++;
            if (syn_en) en_high++;
            if (!syn_en && p_en) begin
                if (frames > 0) check(en_high >= 2*H, "R8 strobe gap", en_high, 2*H);
                nbits = 0;
                sh = '0;
                since_fall = 0;
            end
            if (syn_clk && !p_clk) begin
                if (nbits == 0) check(since_fall == 2*H, "R8 first edge", since_fall, 2*H);
                else            check(since_rise == 2*H, "R8 bit period", since_rise, 2*H);
                sh = {sh[30:0], syn_dat};
                nbits++;
                since_rise = 0;
            end
            if (syn_clk && p_clk && syn_dat != p_dat) check(1'b0, "R6 data moved", 1, 0);
            if (syn_clk && syn_en) check(1'b0, "R7 clock outside frame", 1, 0);
            if (!syn_en && !busy) check(1'b0, "R9 busy in frame", 0, 1);
            if (syn_en && !p_en) begin
                if (frames < 32) begin
                    words[frames] = sh;
                    lens[frames]  = nbits;
                end
                frames++;
                en_high = 1;
            end
            if (done) done_cnt++;
        end
        p_en  = syn_en;
        p_clk = syn_clk;
        p_dat = syn_dat;
    end

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        repeat (4*H) @(negedge clk);
    endtask

    task automatic pulse_reload();
        @(negedge clk);
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
    endtask

    // Channel value and expected divider word
    localparam logic [23:0] VEC [6] = '{
        {8'd0,   16'd876},
        {8'd255, 16'd1131},
        {8'h94,  16'd1024},
        {8'h93,  16'd1023},
        {8'd1,   16'd877},
        {8'd128, 16'd1004}
    };

    initial begin
        int f0, d0;
        rst_n = 1'b0;
        reload = 1'b0;
        chan_sel = 8'd5;
        repeat (3) @(negedge clk);
        check(syn_en == 1'b1, "R1 en", int'(syn_en), 1);
        check(syn_clk == 1'b0, "R1 clk", int'(syn_clk), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(syn_en == 1'b1 && !busy, "R1 after release", int'(syn_en), 1);
        wait_done();
        check(frames == 3, "R2 frame count", frames, 3);
        check(words[0] == 32'h64 && lens[0] == 8, "R3 setup word", int'(words[0]), 'h64);
        check(lens[0] == 8, "R3 setup length", lens[0], 8);
        check(words[1] == 32'd40, "R4 reference word", int'(words[1]), 40);
        check(lens[1] == 15, "R4 reference length", lens[1], 15);
        check(words[2] == 32'd881, "R5 divider word", int'(words[2]), 881);
        check(lens[2] == 16, "R5 divider length", lens[2], 16);
        check(done_cnt == 1, "R9 done count", done_cnt, 1);
        check(busy == 1'b0, "R9 busy cleared", int'(busy), 0);

        repeat (200) @(negedge clk);
        check(frames == 3, "R12 no further frames", frames, 3);
        check(syn_en == 1'b1 && syn_clk == 1'b0, "R12 lines quiet", int'(syn_en), 1);

        // Vector table walk: reload in idle, one divider frame each
        for (int v = 0; v < 6; v++) begin
            f0 = frames;
            chan_sel = VEC[v][23:16];
            pulse_reload();
            wait_done();
            check(frames == f0 + 1, "R10 single frame", frames - f0, 1);
            check(words[f0] == 32'(VEC[v][15:0]), "R5 divider value", int'(words[f0]), int'(VEC[v][15:0]));
            check(lens[f0] == 16, "R5 divider length", lens[f0], 16);
        end

        // Reload while busy is ignored; channel taken at start
        f0 = frames;
        d0 = done_cnt;
        chan_sel = 8'd10;
        pulse_reload();
        repeat (5) @(negedge clk);
        chan_sel = 8'd77;
        check(busy == 1'b1, "R11 busy during transfer", int'(busy), 1);
        pulse_reload();
        wait_done();
        repeat (100) @(negedge clk);
        check(frames == f0 + 1, "R11 no extra frame", frames - f0, 1);
        check(done_cnt == d0 + 1, "R11 no extra done", done_cnt - d0, 1);
        check(words[f0] == 32'd886, "R10 channel sampled at start", int'(words[f0]), 886);

        // Reset again mid-idle: full load repeats
        f0 = frames;
        chan_sel = 8'd200;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(syn_en == 1'b1 && !syn_clk && !busy && !done, "R1 reset again", int'(syn_en), 1);
        rst_n = 1'b1;
        wait_done();
        check(frames == f0 + 3, "R2 full load after reset", frames - f0, 3);
        check(words[f0] == 32'h64 && words[f0+1] == 32'd40, "R2 order", int'(words[f0]), 'h64);
        check(words[f0+2] == 32'd1076, "R5 divider after reset", int'(words[f0+2]), 1076);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule